// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This controller switches a set of power domains off and back on at software's request. Software talks to it through a 32-bit register port with plain read and write strobes. The domains are arranged in groups of channels. Each group has its own register bank with these parts:

- a power state view;
- request registers for shutoff and for resume;
- "in progress" views for each direction;
- an error register for refused requests.

Only one sequence runs at a time. The power switch is modelled as a countdown of `SETTLE` cycles. When it ends, the domain's state flips. If enabled, the end of the sequence also latches a completion flag that can raise the interrupt line.

A request is refused in three cases: the sequencer is already busy, the written value is not a single channel bit, or the write lands on the very cycle a sequence finishes. A refused request leaves an error bit behind so that software can try again. External hardware can also ask for a domain change through request pins. A software-owned block mask can hold off those requests. The bus port has no back-pressure: a write is always taken in its cycle, and acceptance is reported only through the ready and error bits.

Domain index `d` belongs to group `d / CH_PER_GRP`, channel `d % CH_PER_GRP`. Default parameters: 2 groups of 4 channels, a settle time of 8 cycles, 8-bit byte addresses.

Top module: `pdom_seq_ctrl`

## Requirements
- R1: After reset, every domain reads powered on and the status register (0x00) reads 3. The completion, enable and mask registers read 0, and `irq` is low.
- R2: A write of a single channel bit to a group's shutoff request register (group base 0x40 + 0x20·g, offset 0x04) starts a shutoff when the controller is idle. While it runs, status bits [1:0] read 0 and the channel's bit in the shutoff-active register (offset 0x08) reads 1. `SETTLE` cycles after the accepting edge, the channel's bit in the power state register (offset 0x00) reads 1, meaning off.
- R3: A single-bit write to the resume request register (offset 0x0C) runs the same way and clears the power state bit. The resume-active register is at offset 0x10.
- R4: A request written while a sequence is running is refused. This includes a write on the edge where the sequence completes. The channel's bit in the error register (offset 0x14) is set, and that domain's power state is unchanged.
- R5: A request whose written value is not exactly one channel bit is refused. Every channel bit that was written is set in the error register, and no sequence starts.
- R6: An accepted request clears the error bit of its channel.
- R7: On completion, completion bit `g·CH_PER_GRP + c` (register 0x04) is set only if the same bit of the enable register (0x0C) is set.
- R8: Writing ones to the clear register (0x08) clears those completion bits. If a clear and a completion of the same bit fall on one edge, the bit ends up set.
- R9: `irq` is high exactly when some completion bit is set with its enable set and its mask bit (register 0x10) clear. A masked completion bit still reads back as 1.
- R10: A pulse on `ext_off_req[d]` or `ext_on_req[d]` starts that sequence when the controller is idle, no bus request is present and bit d of the block mask (register 0x14) is 0. When the mask bit is 1, the pulse has no effect. Among several pending pins, the lowest index wins, and shutoff wins over resume on the same index.
- R11: If a bus request and an external request arrive on the same edge, the bus request is the one that runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; `rdata` is valid the cycle after |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| ext_off_req | input | ND | External shutoff request pins, one per domain |
| ext_on_req | input | ND | External resume request pins, one per domain |
| irq | output | 1 | Interrupt to the CPU |

## Verification
Two sets of events can fall on the same edge.

The first is a sequence completing while software writes something. The bench starts a sequence and waits exactly `SETTLE-1` cycles. It then writes either the completion clear register or a new request, so that the write is accepted on the completion edge. It then checks two things: the completion bit survives the clear, and the new request is refused with its error bit set.

The second is a bus request and an external pin request arriving on the same edge. The bench drives both in one cycle and checks that only the bus target changes state. Randomly chosen domains, directions and enable settings are then compared against a bench model of power state and completion flags.

// File: rtl/pdsc_pkg.sv
package pdsc_pkg;
  typedef enum logic {DIR_OFF = 1'b0, DIR_ON = 1'b1} dir_e;

  // global register offsets
  localparam logic [7:0] A_STAT = 8'h00;
  localparam logic [7:0] A_ISR  = 8'h04;
  localparam logic [7:0] A_ICLR = 8'h08;
  localparam logic [7:0] A_IEN  = 8'h0C;
  localparam logic [7:0] A_IMSK = 8'h10;
  localparam logic [7:0] A_XMSK = 8'h14;

  // group banks
  localparam logic [7:0] BANK_BASE = 8'h40;
  localparam int         STRIDE_LG = 5;   // 0x20 bytes per bank

  localparam logic [4:0] O_PSTATE = 5'h00;
  localparam logic [4:0] O_OFFREQ = 5'h04;
  localparam logic [4:0] O_OFFACT = 5'h08;
  localparam logic [4:0] O_ONREQ  = 5'h0C;
  localparam logic [4:0] O_ONACT  = 5'h10;
  localparam logic [4:0] O_ERR    = 5'h14;
endpackage

// File: rtl/pdsc_seq.sv
module pdsc_seq
  import pdsc_pkg::*;
#(
  parameter int ND     = 8,
  parameter int SETTLE = 8,
  localparam int IW    = (ND > 1) ? $clog2(ND) : 1,
  localparam int CW    = (SETTLE > 1) ? $clog2(SETTLE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] start_dom,
  input  dir_e          start_dir,
  output logic          busy,
  output logic          done,
  output logic [IW-1:0] done_dom,
  output logic [ND-1:0] pwr_off,
  output logic [ND-1:0] act_off,
  output logic [ND-1:0] act_on
);
  logic [CW-1:0] cnt;
  dir_e          cur_dir;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      done_dom <= '0;
      cur_dir  <= DIR_ON;
      pwr_off  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        cnt      <= CW'(SETTLE - 1);
        done_dom <= start_dom;
        cur_dir  <= start_dir;
      end
    end else if (cnt == '0) begin
      busy              <= 1'b0;
      pwr_off[done_dom] <= (cur_dir == DIR_OFF);
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);

  for (genvar d = 0; d < ND; d++) begin : g_act
    assign act_off[d] = busy && (int'(done_dom) == d) && (cur_dir == DIR_OFF);
    assign act_on[d]  = busy && (int'(done_dom) == d) && (cur_dir == DIR_ON);
  end
endmodule

// File: rtl/pdsc_irq.sv
module pdsc_irq #(
  parameter int ND = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [ND-1:0] set_vec,
  input  logic          clr_wr,
  input  logic          ien_wr,
  input  logic          imsk_wr,
  input  logic [ND-1:0] wdata,
  output logic [ND-1:0] isr,
  output logic [ND-1:0] ien,
  output logic [ND-1:0] imsk,
  output logic          irq
);
  logic [ND-1:0] clr_vec;
  assign clr_vec = clr_wr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr  <= '0;
      ien  <= '0;
      imsk <= '0;
    end else begin
      isr <= (isr & ~clr_vec) | (set_vec & ien);
      if (ien_wr)  ien  <= wdata;
      if (imsk_wr) imsk <= wdata;
    end
  end

  assign irq = |(isr & ien & ~imsk);
endmodule

// File: rtl/pdom_seq_ctrl.sv
module pdom_seq_ctrl
  import pdsc_pkg::*;
#(
  parameter int N_GRP      = 2,
  parameter int CH_PER_GRP = 4,
  parameter int SETTLE     = 8,
  parameter int ADDR_W     = 8,
  localparam int ND        = N_GRP * CH_PER_GRP,
  localparam int IW        = (ND > 1) ? $clog2(ND) : 1,
  localparam int CIW       = (CH_PER_GRP > 1) ? $clog2(CH_PER_GRP) : 1,
  localparam int BW        = ADDR_W - STRIDE_LG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [ND-1:0]     ext_off_req,
  input  logic [ND-1:0]     ext_on_req,
  output logic              irq
);
  localparam logic [31:0] CH_MASK = (32'd1 << CH_PER_GRP) - 32'd1;

  // address decode
  logic [ADDR_W-1:0]    off_full;
  logic [BW-1:0]        bank_idx;
  logic [STRIDE_LG-1:0] boff;
  logic                 in_bank;
  assign off_full = addr - ADDR_W'(BANK_BASE);
  assign bank_idx = off_full[ADDR_W-1:STRIDE_LG];
  assign boff     = off_full[STRIDE_LG-1:0];
  assign in_bank  = (addr >= ADDR_W'(BANK_BASE)) && (int'(bank_idx) < N_GRP);

  // bus request
  logic [CH_PER_GRP-1:0] ch_bits;
  logic [CIW-1:0]        ch_idx;
  logic                  bus_off, bus_on, bus_req, onehot, bus_accept;
  assign ch_bits = wdata[CH_PER_GRP-1:0];
  assign bus_off = wr_en && in_bank && (boff == O_OFFREQ);
  assign bus_on  = wr_en && in_bank && (boff == O_ONREQ);
  assign bus_req = bus_off || bus_on;
  assign onehot  = ((wdata & ~CH_MASK) == 32'd0) && ($countones(ch_bits) == 1);

  always_comb begin
    ch_idx = '0;
    for (int c = 0; c < CH_PER_GRP; c++)
      if (ch_bits[c]) ch_idx = CIW'(c);
  end

  // sequencer
  logic          seq_busy, seq_done;
  logic [IW-1:0] done_dom;
  logic [ND-1:0] pwr_off, act_off, act_on;
  assign bus_accept = bus_req && onehot && !seq_busy;

  // external requests
  logic [ND-1:0] xmsk, ext_pend;
  logic [IW-1:0] ext_pick;
  logic          ext_accept;
  assign ext_pend = (ext_off_req | ext_on_req) & ~xmsk;

  always_comb begin
    ext_pick = '0;
    for (int d = ND - 1; d >= 0; d--)
      if (ext_pend[d]) ext_pick = IW'(d);
  end
  assign ext_accept = !bus_req && !seq_busy && (|ext_pend);

  logic          start;
  logic [IW-1:0] start_dom;
  dir_e          start_dir;
  assign start     = bus_accept || ext_accept;
  assign start_dom = bus_accept ? IW'(int'(bank_idx) * CH_PER_GRP + int'(ch_idx)) : ext_pick;
  assign start_dir = bus_accept ? (bus_on ? DIR_ON : DIR_OFF)
                                : (ext_off_req[ext_pick] ? DIR_OFF : DIR_ON);

  pdsc_seq #(.ND(ND), .SETTLE(SETTLE)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_dom (start_dom),
    .start_dir (start_dir),
    .busy      (seq_busy),
    .done      (seq_done),
    .done_dom  (done_dom),
    .pwr_off   (pwr_off),
    .act_off   (act_off),
    .act_on    (act_on)
  );

  // completion flags
  logic [ND-1:0] set_vec, isr, ien, imsk;
  for (genvar d = 0; d < ND; d++) begin : g_set
    assign set_vec[d] = seq_done && (int'(done_dom) == d);
  end

  pdsc_irq #(.ND(ND)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_wr  (wr_en && (addr == ADDR_W'(A_ICLR))),
    .ien_wr  (wr_en && (addr == ADDR_W'(A_IEN))),
    .imsk_wr (wr_en && (addr == ADDR_W'(A_IMSK))),
    .wdata   (wdata[ND-1:0]),
    .isr     (isr),
    .ien     (ien),
    .imsk    (imsk),
    .irq     (irq)
  );

  // error and block-mask registers
  logic [ND-1:0] err;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err  <= '0;
      xmsk <= '0;
    end else begin
      if (wr_en && (addr == ADDR_W'(A_XMSK))) xmsk <= wdata[ND-1:0];
      if (start) begin
        err[start_dom] <= 1'b0;
      end else if (bus_req) begin
        for (int g = 0; g < N_GRP; g++)
          if (int'(bank_idx) == g)
            err[g*CH_PER_GRP +: CH_PER_GRP] <= err[g*CH_PER_GRP +: CH_PER_GRP] | ch_bits;
      end
    end
  end

  // read path
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = 32'd0;
    if (!in_bank) begin
      case (addr)
        ADDR_W'(A_STAT): rd_mux = {30'd0, !seq_busy, !seq_busy};
        ADDR_W'(A_ISR):  rd_mux = 32'(isr);
        ADDR_W'(A_IEN):  rd_mux = 32'(ien);
        ADDR_W'(A_IMSK): rd_mux = 32'(imsk);
        ADDR_W'(A_XMSK): rd_mux = 32'(xmsk);
        default:         rd_mux = 32'd0;
      endcase
    end else begin
      for (int g = 0; g < N_GRP; g++) begin
        if (int'(bank_idx) == g) begin
          case (boff)
            O_PSTATE: rd_mux = 32'(pwr_off[g*CH_PER_GRP +: CH_PER_GRP]);
            O_OFFACT: rd_mux = 32'(act_off[g*CH_PER_GRP +: CH_PER_GRP]);
            O_ONACT:  rd_mux = 32'(act_on[g*CH_PER_GRP +: CH_PER_GRP]);
            O_ERR:    rd_mux = 32'(err[g*CH_PER_GRP +: CH_PER_GRP]);
            default:  rd_mux = 32'd0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= 32'd0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/pdsc_chk.sv
module pdsc_chk #(
  parameter int ND     = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic [ND-1:0]     pwr_off,
  input logic [ND-1:0]     isr,
  input logic [ND-1:0]     ien,
  input logic [ND-1:0]     imsk,
  input logic              irq,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata
);
  // R2
  state_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_off != $past(pwr_off)) |-> $past(busy));

  // R2
  single_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pwr_off ^ $past(pwr_off)) <= 1);

  // R2
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == '0) && busy) |=> (rdata[1:0] == 2'b00));

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);

  // R7
  latch_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr & ~$past(isr) & ~$past(ien)) == '0));

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((isr & ~imsk) != '0));
endmodule

bind pdom_seq_ctrl pdsc_chk #(.ND(ND), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (seq_busy),
  .pwr_off (pwr_off),
  .isr     (isr),
  .ien     (ien),
  .imsk    (imsk),
  .irq     (irq),
  .rd_en   (rd_en),
  .addr    (addr),
  .rdata   (rdata)
);

// File: tb/tb_pdom_seq_ctrl.sv
`timescale 1ns/100ps
module tb_pdom_seq_ctrl;
  localparam int CH = 4;
  localparam int NG = 2;
  localparam int ND = CH * NG;
  localparam int ST = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [ND-1:0] ext_off_req = '0, ext_on_req = '0;
  logic          irq;

  int checks = 0, errors = 0;
  logic [ND-1:0] exp_off, exp_isr;

  always #2.5 clk = ~clk;

  pdom_seq_ctrl #(.N_GRP(NG), .CH_PER_GRP(CH), .SETTLE(ST)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ext_off_req(ext_off_req),
    .ext_on_req(ext_on_req), .irq(irq));

  function automatic logic [7:0] bank(input int g, input logic [7:0] o);
    return 8'h40 + 8'(g * 32) + o;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic bw(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic br(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    br(a, v);
    chk(tag, v, exp);
  endtask

  task automatic settle();
    repeat (ST + 2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rchk("R1 status", 8'h00, 32'd3);
    rchk("R1 pstate", bank(0, 8'h00), 32'd0);
    rchk("R1 isr", 8'h04, 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);

    // R2 shutoff of domain 2
    bw(8'h0C, 32'hFF);
    bw(bank(0, 8'h04), 32'h4);
    rchk("R2 busy status", 8'h00, 32'd0);
    rchk("R2 off active", bank(0, 8'h08), 32'h4);
    settle();
    rchk("R2 pstate", bank(0, 8'h00), 32'h4);
    rchk("R7 isr set", 8'h04, 32'h4);
    chk("R9 irq high", 32'(irq), 32'd1);
    bw(8'h10, 32'h4);
    @(negedge clk);
    chk("R9 irq masked", 32'(irq), 32'd0);
    rchk("R9 masked isr readable", 8'h04, 32'h4);
    bw(8'h10, 32'h0);
    bw(8'h08, 32'h4);
    rchk("R8 cleared", 8'h04, 32'h0);

    // R3 resume of domain 2
    bw(bank(0, 8'h0C), 32'h4);
    rchk("R3 on active", bank(0, 8'h10), 32'h4);
    settle();
    rchk("R3 pstate", bank(0, 8'h00), 32'h0);
    bw(8'h08, 32'hFF);

    // R4 request while busy
    bw(bank(1, 8'h04), 32'h2);
    bw(bank(0, 8'h04), 32'h1);
    rchk("R4 err", bank(0, 8'h14), 32'h1);
    settle();
    rchk("R4 dom0 untouched", bank(0, 8'h00), 32'h0);
    rchk("R4 dom5 off", bank(1, 8'h00), 32'h2);

    // R6 retry clears error
    bw(bank(0, 8'h04), 32'h1);
    rchk("R6 err cleared", bank(0, 8'h14), 32'h0);
    settle();
    rchk("R6 dom0 off", bank(0, 8'h00), 32'h1);

    // R5 non-one-hot
    bw(bank(0, 8'h0C), 32'h3);
    rchk("R5 err bits", bank(0, 8'h14), 32'h3);
    rchk("R5 not started", 8'h00, 32'd3);
    rchk("R5 pstate kept", bank(0, 8'h00), 32'h1);
    bw(bank(0, 8'h0C), 32'h1);
    rchk("R6 partial clear", bank(0, 8'h14), 32'h2);
    settle();
    bw(bank(0, 8'h0C), 32'h2);
    settle();
    rchk("R6 err empty", bank(0, 8'h14), 32'h0);
    rchk("R3 dom0 on", bank(0, 8'h00), 32'h0);

    // R7 no latch without enable
    bw(8'h0C, 32'h0);
    bw(8'h08, 32'hFF);
    bw(bank(0, 8'h04), 32'h8);
    settle();
    rchk("R7 isr stays 0", 8'h04, 32'h0);
    rchk("R2 dom3 off", bank(0, 8'h00), 32'h8);
    bw(8'h0C, 32'hFF);

    // R8 clear on completion edge: set wins
    bw(bank(0, 8'h0C), 32'h8);
    repeat (ST - 1) @(negedge clk);
    bw(8'h08, 32'hFF);
    rchk("R8 set wins", 8'h04, 32'h8);
    bw(8'h08, 32'hFF);

    // R4 request on completion edge is refused
    bw(bank(0, 8'h04), 32'h8);
    repeat (ST - 1) @(negedge clk);
    bw(bank(0, 8'h04), 32'h1);
    rchk("R4 edge refused", bank(0, 8'h14), 32'h1);
    settle();
    rchk("R4 edge pstate", bank(0, 8'h00), 32'h8);

    // R10 external requests, blocked then allowed
    bw(8'h14, 32'h10);
    ext_off_req = 8'h10;
    @(negedge clk);
    ext_off_req = '0;
    settle();
    rchk("R10 blocked", bank(1, 8'h00), 32'h2);
    bw(8'h14, 32'h0);
    ext_off_req = 8'h10;
    @(negedge clk);
    ext_off_req = '0;
    settle();
    rchk("R10 allowed", bank(1, 8'h00), 32'h3);

    // R11 bus wins over external on the same edge
    addr = bank(1, 8'h0C); wdata = 32'h2; wr_en = 1'b1; ext_on_req = 8'h10;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; ext_on_req = '0;
    settle();
    rchk("R11 bus won", bank(1, 8'h00), 32'h1);

    // random phase against a model
    bw(8'h08, 32'hFF);
    exp_off = 8'h18;
    exp_isr = '0;
    for (int i = 0; i < 40; i++) begin
      int d;
      bit on, ie;
      d  = int'($urandom % ND);
      on = 1'($urandom % 2);
      ie = 1'($urandom % 2);
      bw(8'h0C, ie ? 32'hFF : 32'h0);
      bw(bank(d / CH, on ? 8'h0C : 8'h04), 32'(1) << (d % CH));
      settle();
      exp_off[d] = !on;
      if (ie) exp_isr[d] = 1'b1;
      rchk("R2 R3 random pstate", bank(d / CH, 8'h00),
           32'(exp_off[(d / CH) * CH +: CH]));
      rchk("R7 random isr", 8'h04, 32'(exp_isr));
      if ($urandom % 3 == 0) begin
        bw(8'h08, 32'hFF);
        exp_isr = '0;
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule